// File: doc/BRIEF.md
# Accumulator-Based 8-bit Processor Core

This block is a small multicycle processor that runs a fixed sixteen-opcode, byte-coded program out of a 256-byte memory. Its state is modest:

- an accumulator;
- a count register for counted loops;
- a temporary register that pairs with the accumulator for addition and swapping;
- a one-deep return register for subroutine calls;
- a zero flag.

Each instruction occupies one or two bytes. The core fetches the first byte, fetches an operand byte when the opcode needs one, then executes. Execution may stall on the byte input or byte output handshake.

A host places a program in memory and releases reset. Data flows through the input and output ports, and the host waits for the halted output. The exception output carries a 4-bit code. The code is held steady after a halt instruction. A non-halting exception instruction shows its code with a one-cycle strobe.

The memory port is a synchronous read. The core drives an address with a read strobe, and the byte comes back on the next cycle.

Top module: `acc8_core`

## Requirements
- R1: After reset the first read is from address 0, halted_o is 0, and the accumulator, count, temporary and zero flag are all 0 (a PUT first outputs 0x00, and a SWAP then PUT also outputs 0x00).
- R2: The opcode is bits 7:4 of the first byte: NOOP=0, GET=1, PUT=2, ADD=3, AND=4, SHR=5, SHL=6, IMM=7, DEC=8, SWAP=9, EXC=A, BRZ=B, BR=C, CALL=D, RET=E, HALT=F. AND, IMM, BRZ, BR and CALL take a second byte, and all other opcodes are one byte. The pointer steps by the instruction length unless a jump loads it.
- R3: IMM writes its second byte to every register selected by bits of its low nibble: bit 0 selects the count register, bit 1 the accumulator, bit 2 the temporary. A nibble of 0 loads nothing.
- R4: ADD replaces the accumulator with the accumulator plus the temporary, modulo 256.
- R5: AND sets the zero flag when the accumulator ANDed with the mask byte is 0 and clears it otherwise. The accumulator does not change.
- R6: SHL and SHR shift the accumulator by one bit and fill the vacated bit with 0.
- R7: SWAP exchanges the accumulator and the temporary.
- R8: DEC decrements the count register and sets the zero flag exactly when the result is 0. BRZ jumps to its target only when the zero flag is 1. BR always jumps.
- R9: CALL stores its own address plus 2 in the return register and jumps. RET jumps to the stored address.
- R10: GET raises in_ready_o and waits until in_valid_i, then loads in_data_i into the accumulator. PUT holds out_valid_o with a steady out_data_o equal to the accumulator until out_ready_i.
- R11: EXC pulses exc_valid_o for exactly one cycle with its low nibble on exc_code_o, and execution continues with the next instruction.
- R12: HALT sets halted_o, which stays set until reset. It puts its low nibble on exc_code_o, clears the pointer so mem_addr_o reads 0, and stops all memory reads.
- R13: The first byte arrives one cycle after its read. A one-byte instruction takes 3 cycles and a two-byte instruction takes 4 cycles, not counting handshake waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the strobe |
| in_data_i | input | 8 | Input port byte |
| in_valid_i | input | 1 | Input byte available |
| in_ready_o | output | 1 | Core accepts the input byte (GET executing) |
| out_data_o | output | 8 | Output port byte |
| out_valid_o | output | 1 | Output byte presented (PUT executing) |
| out_ready_i | input | 1 | Receiver takes the output byte |
| halted_o | output | 1 | Core has executed HALT |
| exc_code_o | output | 4 | Last exception or halt code |
| exc_valid_o | output | 1 | One-cycle strobe for EXC |

## Verification
A corrupted register or flag stays hidden until a PUT exposes the accumulator or a conditional branch changes the path. A bad temporary or count value therefore shows up only after the SWAP, ADD or DEC that consumes it, one instruction (3 to 4 cycles) later at the earliest. A wrong pointer or length decode shows at once, in the next cycle, on mem_addr_o. Usually it also changes the output stream or the halt code. The directed programs are chained so that each register's value ends up at the output port or selects a branch target.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  typedef enum logic [3:0] {
    OP_NOOP = 4'h0, OP_GET  = 4'h1, OP_PUT  = 4'h2, OP_ADD  = 4'h3,
    OP_AND  = 4'h4, OP_SHR  = 4'h5, OP_SHL  = 4'h6, OP_IMM  = 4'h7,
    OP_DEC  = 4'h8, OP_SWAP = 4'h9, OP_EXC  = 4'hA, OP_BRZ  = 4'hB,
    OP_BR   = 4'hC, OP_CALL = 4'hD, OP_RET  = 4'hE, OP_HALT = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_OPND, ST_EXEC, ST_HALT
  } state_e;

  function automatic logic has_operand(op_e op);
    return op inside {OP_AND, OP_IMM, OP_BRZ, OP_BR, OP_CALL};
  endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] instr_i,
  output op_e           op_o,
  output logic [3:0]    nib_o,
  output logic          two_byte_o
);
  assign op_o       = op_e'(instr_i[7:4]);
  assign nib_o      = instr_i[3:0];
  assign two_byte_o = has_operand(op_o);
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] md_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] res_o,
  output logic          mask_zero_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = ac_i + md_i;
      OP_SHR:  res_o = ac_i >> 1;
      OP_SHL:  res_o = ac_i << 1;
      default: res_o = ac_i;
    endcase
  end

  assign mask_zero_o = (ac_i & mask_i) == '0;
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          halted_o,
  output logic [3:0]    exc_code_o,
  output logic          exc_valid_o
);
  localparam int NW = 4;

  state_e        state_q, state_n;
  logic [AW-1:0] ip_q, ip_n, sr_q, sr_n;
  logic [DW-1:0] ir_q, opnd_q;
  logic [DW-1:0] ac_q, ac_n, cr_q, cr_n, md_q, md_n;
  logic          z_q, z_n;
  logic [NW-1:0] exc_q, exc_n;
  logic          excv_q, excv_n;

  op_e           op;
  logic [NW-1:0] nib;
  logic          two_byte;
  logic [DW-1:0] alu_res;
  logic          mask_zero;
  logic          fetch_two;
  logic [AW-1:0] ip_next_seq, target;
  logic [DW-1:0] cr_dec;

  acc8_decode #(.DW(DW)) u_dec (
    .instr_i    (ir_q),
    .op_o       (op),
    .nib_o      (nib),
    .two_byte_o (two_byte)
  );

  acc8_alu #(.DW(DW)) u_alu (
    .op_i        (op),
    .ac_i        (ac_q),
    .md_i        (md_q),
    .mask_i      (opnd_q),
    .res_o       (alu_res),
    .mask_zero_o (mask_zero)
  );

  assign fetch_two   = has_operand(op_e'(mem_rdata_i[7:4]));
  assign ip_next_seq = ip_q + (two_byte ? AW'(2) : AW'(1));
  assign target      = opnd_q[AW-1:0];
  assign cr_dec      = cr_q - DW'(1);

  // memory port: opcode byte at ip, operand byte at ip+1
  assign mem_rd_o   = (state_q == ST_FETCH) || (state_q == ST_DEC && fetch_two);
  assign mem_addr_o = (state_q == ST_DEC) ? ip_q + AW'(1) : ip_q;

  assign in_ready_o  = (state_q == ST_EXEC) && (op == OP_GET);
  assign out_valid_o = (state_q == ST_EXEC) && (op == OP_PUT);
  assign out_data_o  = ac_q;
  assign halted_o    = (state_q == ST_HALT);
  assign exc_code_o  = exc_q;
  assign exc_valid_o = excv_q;

  always_comb begin
    state_n = state_q;
    ip_n    = ip_q;
    sr_n    = sr_q;
    ac_n    = ac_q;
    cr_n    = cr_q;
    md_n    = md_q;
    z_n     = z_q;
    exc_n   = exc_q;
    excv_n  = 1'b0;
    unique case (state_q)
      ST_FETCH: state_n = ST_DEC;
      ST_DEC:   state_n = fetch_two ? ST_OPND : ST_EXEC;
      ST_OPND:  state_n = ST_EXEC;
      ST_EXEC: begin
        state_n = ST_FETCH;
        ip_n    = ip_next_seq;
        unique case (op)
          OP_NOOP: ;
          OP_GET: begin
            if (in_valid_i) ac_n = in_data_i;
            else begin
              state_n = ST_EXEC;
              ip_n    = ip_q;
            end
          end
          OP_PUT: begin
            if (!out_ready_i) begin
              state_n = ST_EXEC;
              ip_n    = ip_q;
            end
          end
          OP_ADD, OP_SHR, OP_SHL: ac_n = alu_res;
          OP_AND: z_n = mask_zero;
          OP_IMM: begin
            if (nib[0]) cr_n = opnd_q;
            if (nib[1]) ac_n = opnd_q;
            if (nib[2]) md_n = opnd_q;
          end
          OP_DEC: begin
            cr_n = cr_dec;
            z_n  = (cr_dec == '0);
          end
          OP_SWAP: begin
            ac_n = md_q;
            md_n = ac_q;
          end
          OP_EXC: begin
            exc_n  = nib;
            excv_n = 1'b1;
          end
          OP_BRZ: if (z_q) ip_n = target;
          OP_BR:  ip_n = target;
          OP_CALL: begin
            sr_n = ip_next_seq;
            ip_n = target;
          end
          OP_RET: ip_n = sr_q;
          OP_HALT: begin
            ip_n    = '0;
            exc_n   = nib;
            state_n = ST_HALT;
          end
          default: ;
        endcase
      end
      ST_HALT: ;
      default: state_n = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ip_q    <= '0;
      sr_q    <= '0;
      ir_q    <= '0;
      opnd_q  <= '0;
      ac_q    <= '0;
      cr_q    <= '0;
      md_q    <= '0;
      z_q     <= 1'b0;
      exc_q   <= '0;
      excv_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ip_q    <= ip_n;
      sr_q    <= sr_n;
      ac_q    <= ac_n;
      cr_q    <= cr_n;
      md_q    <= md_n;
      z_q     <= z_n;
      exc_q   <= exc_n;
      excv_q  <= excv_n;
      if (state_q == ST_DEC)  ir_q   <= mem_rdata_i;
      if (state_q == ST_OPND) opnd_q <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [DW-1:0] out_data_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic          halted_o,
  input logic          exc_valid_o
);
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R10
  in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o);

  // R11
  exc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> !exc_valid_o);

  // R12
  halt_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && !mem_rd_o);

  // R12
  halt_ip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> mem_addr_o == '0);

  // R13
  rd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !in_ready_o && !out_valid_o);
endmodule

bind acc8_core acc8_core_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .halted_o    (halted_o),
  .exc_valid_o (exc_valid_o)
);

// File: tb/acc8_core_tb_top.sv
`timescale 1ns/1ps
module acc8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr;
  logic       mem_rd;
  logic [7:0] mem_rdata = '0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       halted;
  logic [3:0] exc_code;
  logic       exc_valid;

  logic [7:0] mem [256];
  logic [7:0] in_q [$];
  logic [7:0] out_q [$];
  logic       in_en = 1'b1;
  int         exc_cnt = 0;
  logic [3:0] exc_last = '0;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  acc8_core dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .halted_o(halted), .exc_code_o(exc_code), .exc_valid_o(exc_valid)
  );

  // synchronous memory model
  initial forever begin
    @(posedge clk);
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // port agents: sample at negedge, update just after posedge
  initial forever begin
    logic in_hs;
    @(negedge clk);
    in_hs = in_valid && in_ready;
    if (out_valid && out_ready) out_q.push_back(out_data);
    if (exc_valid) begin
      exc_cnt++;
      exc_last = exc_code;
    end
    @(posedge clk);
    #1;
    if (in_hs && in_q.size() > 0) void'(in_q.pop_front());
    in_valid = in_en && (in_q.size() > 0);
    in_data  = (in_q.size() > 0) ? in_q[0] : 8'h00;
  end

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act cycles %0d exp below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic load(logic [7:0] p [$]);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    foreach (p[i]) mem[i] = p[i];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    out_q.delete();
    exc_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " halt reached"}, halted, 1'b1);
  endtask

  task automatic chk_outs(string req, logic [7:0] e [$]);
    chk({req, " output count"}, out_q.size(), e.size());
    foreach (e[i]) if (i < out_q.size()) chk({req, " output byte"}, out_q[i], e[i]);
  endtask

  task automatic t_reset();
    load('{8'h20, 8'h90, 8'h20, 8'hF0});
    do_reset();
    chk("R1 first read addr", mem_addr, 8'h00);
    chk("R1 first read strobe", mem_rd, 1'b1);
    chk("R1 halted clear", halted, 1'b0);
    chk("R1 out_valid clear", out_valid, 1'b0);
    chk("R1 exc code clear", exc_code, 4'h0);
    wait_halt("R1");
    chk_outs("R1 cleared ac/md", '{8'h00, 8'h00});
  endtask

  task automatic t_loop();
    // counted loop calling get/swap/put twice
    load('{8'h71, 8'h02, 8'hD0, 8'h0A, 8'h80, 8'hB0, 8'h09, 8'hC0, 8'h02,
           8'hF0, 8'h10, 8'h90, 8'h20, 8'hE0});
    in_q = '{8'h11, 8'h22};
    do_reset();
    wait_halt("R9");
    chk_outs("R9 R8 R7 R2 loop", '{8'h00, 8'h11});
    chk("R8 halt code", exc_code, 4'h0);
  endtask

  task automatic t_add();
    load('{8'h72, 8'hF0, 8'h74, 8'h25, 8'h30, 8'h20, 8'hF3});
    do_reset();
    wait_halt("R4");
    chk_outs("R4 wrap sum", '{8'h15});
    chk("R12 halt code 3", exc_code, 4'h3);
  endtask

  task automatic t_and();
    load('{8'h72, 8'h5A, 8'h40, 8'hA5, 8'hB0, 8'h08, 8'hF1, 8'h00, 8'h20,
           8'h40, 8'h02, 8'hB0, 8'h0E, 8'h20, 8'hF2});
    do_reset();
    wait_halt("R5");
    chk_outs("R5 and flag/ac kept", '{8'h5A, 8'h5A});
    chk("R5 path code", exc_code, 4'h2);
  endtask

  task automatic t_shift();
    load('{8'h72, 8'h81, 8'h60, 8'h20, 8'h50, 8'h20, 8'h50, 8'h20, 8'hF4});
    do_reset();
    wait_halt("R6");
    chk_outs("R6 zero fill", '{8'h02, 8'h01, 8'h00});
  endtask

  task automatic t_imm();
    load('{8'h76, 8'h3C, 8'h20, 8'h90, 8'h20, 8'h70, 8'h99, 8'h20,
           8'h71, 8'h01, 8'h80, 8'hB0, 8'h0E, 8'hF1, 8'hF2});
    do_reset();
    wait_halt("R3");
    chk_outs("R3 mask loads", '{8'h3C, 8'h3C, 8'h3C});
    chk("R3 count loaded", exc_code, 4'h2);
  endtask

  task automatic t_exc();
    load('{8'hA7, 8'h72, 8'h05, 8'h20, 8'hF9});
    do_reset();
    wait_halt("R11");
    chk("R11 pulse count", exc_cnt, 1);
    chk("R11 pulse code", exc_last, 4'h7);
    chk_outs("R11 continues", '{8'h05});
    chk("R11 halt code after", exc_code, 4'h9);
  endtask

  task automatic t_timing_halt();
    int n = 0;
    load('{8'h00, 8'h00, 8'h72, 8'h00, 8'hF5});
    do_reset();
    while (!halted && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk("R13 cycles to halt", n, 13);
    chk("R12 ip cleared", mem_addr, 8'h00);
    chk("R12 code", exc_code, 4'h5);
    repeat (20) @(negedge clk);
    chk("R12 still halted", halted, 1'b1);
    chk("R12 no reads", mem_rd, 1'b0);
    chk("R12 no output", out_q.size(), 0);
  endtask

  task automatic t_handshake();
    int n = 0;
    load('{8'h72, 8'h6B, 8'h20, 8'h10, 8'h20, 8'hF0});
    out_ready = 1'b0;
    in_en = 1'b0;
    in_q = '{8'hE4};
    do_reset();
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 out held", out_valid, 1'b1);
      chk("R10 out data", out_data, 8'h6B);
    end
    out_ready = 1'b1;
    n = 0;
    while (!in_ready && n < 50) begin @(negedge clk); n++; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 get waits", in_ready, 1'b1);
      chk("R10 no out while get", out_valid, 1'b0);
    end
    in_en = 1'b1;
    wait_halt("R10");
    chk_outs("R10 stream", '{8'h6B, 8'hE4});
  endtask

  initial begin
    t_reset();
    t_loop();
    t_add();
    t_and();
    t_shift();
    t_imm();
    t_exc();
    t_timing_halt();
    t_handshake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule